// File: doc/BRIEF.md
# ASCII Command Frame Parser

This block sits behind a UART receiver in a power-supply test controller. It takes one received byte per strobe and recognises text command frames of the form `!NAME;f1;f2;...;#`. Each frame starts with `!` and an upper-case mnemonic. A semicolon-separated list of decimal fields follows, and the two characters `;#` end the frame. The short link request `!!!` is the one exception, and it needs no terminator. Digits are folded into binary while they arrive, so no text buffer is kept.

A good frame gives a one-cycle `frm_valid` pulse. With it come an enumerated command code, the number of fields and up to six field values. A frame that breaks the syntax gives a one-cycle `err_valid` pulse with a reason code, and the parser then drops bytes until the next `!`. A `!` in the middle of a frame discards that frame without an error and starts a new one.

Top module: `cmd_frame_parser`

## Requirements
- R1: During reset and on the first cycle after it, `frm_valid` and `err_valid` are low, and `frm_cmd`, `frm_nfields` and `frm_fields` read zero.
- R2: A terminated frame with a known mnemonic and the right field count gives `frm_valid` for one cycle. The pulse comes on the cycle after the `#` byte is accepted. The command codes are SC (2 fields) = 2, TRO (3 fields) = 3, TRF (1 field) = 4, PN = 5, PF = 6 and GV = 7, where the last three take no fields.
- R3: The three bytes `!!!` give a frame with code 1 and zero fields on the cycle after the third `!`, without any terminator.
- R4: Each field of 1 to 5 decimal digits, leading zeros allowed, appears as its binary value. Field k (counting from 0 in arrival order) sits at `frm_fields[17*k +: 17]`. Slots the frame did not fill read zero.
- R5: A sixth digit in one field gives `err_valid` with code 1 (overflow) on the cycle after that digit.
- R6: Code 0 (syntax) is reported in these cases: any byte other than `!`, a digit or `;` inside a field; anything but a digit or `#` after a `;`; and a byte after the opening `!` that is neither an upper-case letter nor `!`.
- R7: A mnemonic that is not in the R2 table, or that is longer than three letters, gives code 2 (unknown). The error is raised at its `;` or at its fourth letter.
- R8: A field count that does not match the command gives code 3 (count) at the `#`. A seventh field gives code 3 at its closing `;`.
- R9: A `!` in the middle of a frame discards the partial frame without any strobe. The bytes that follow are parsed as a new frame, with all field slots cleared.
- R10: After an error, or before any frame, every byte except `!` is ignored and produces no strobe.
- R11: `frm_valid` and `err_valid` are never high together, and neither stays high for two cycles in a row.
- R12: Bytes presented while `rx_valid` is low have no effect on the parser.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_valid | input | 1 | A received byte is present on `rx_byte` this cycle |
| rx_byte | input | 8 | Received ASCII byte |
| frm_valid | output | 1 | One-cycle strobe: a decoded frame is on the outputs |
| frm_cmd | output | 3 | Command code (see R2, R3) |
| frm_nfields | output | 3 | Number of fields in the frame |
| frm_fields | output | 102 | Six 17-bit binary field values, slot 0 in the low bits |
| err_valid | output | 1 | One-cycle strobe: the frame was rejected |
| err_code | output | 2 | 0 syntax, 1 overflow, 2 unknown mnemonic, 3 field count |

## Verification
The bench targets the boundaries where a parser of this kind tends to go wrong:
- **Field width:** a five-digit field of 99999 must convert exactly, while a sixth digit must be refused. A digit counter that is off by one would either truncate a legal current or let a value wrap past 17 bits.
- **Restart:** a `!` in the middle of a frame is followed by a field-less command. A design that forgets to clear its field slots would show stale values there.
- **Recovery after an error:** trailing `;#` bytes are sent after a rejected frame. A design that does not resync would report a phantom frame or a second error.
- **Field count and idle bytes:** both too few and too many fields are sent, and `!` bytes are held on the bus with `rx_valid` low. A design that ignores the qualifier would turn those idle bytes into a link request.

// File: rtl/cmd_pkg.sv
`timescale 1ns/1ps
// Package: shared types for the command frame parser.
// Assumes 8-bit ASCII input; codes here are visible at the top ports.
package cmd_pkg;

    typedef enum logic [2:0] {
        CMD_NONE = 3'd0,
        CMD_LINK = 3'd1,
        CMD_SC   = 3'd2,
        CMD_TRO  = 3'd3,
        CMD_TRF  = 3'd4,
        CMD_PN   = 3'd5,
        CMD_PF   = 3'd6,
        CMD_GV   = 3'd7
    } cmd_code_e;

    typedef enum logic [1:0] {
        ERR_SYNTAX   = 2'd0,
        ERR_OVERFLOW = 2'd1,
        ERR_UNKNOWN  = 2'd2,
        ERR_COUNT    = 2'd3
    } err_code_e;

    typedef enum logic [2:0] {
        ST_HUNT  = 3'd0,
        ST_BANG1 = 3'd1,
        ST_BANG2 = 3'd2,
        ST_NAME  = 3'd3,
        ST_SEP   = 3'd4,
        ST_FIELD = 3'd5
    } pstate_e;

    localparam logic [7:0] CH_BANG = 8'h21;
    localparam logic [7:0] CH_SEMI = 8'h3B;
    localparam logic [7:0] CH_HASH = 8'h23;

endpackage

// File: rtl/cmd_char_class.sv
`timescale 1ns/1ps
// Module: cmd_char_class
// Purely combinational sorting of one ASCII byte into the classes the
// frame grammar needs. Assumes plain 7-bit ASCII in an 8-bit byte.
module cmd_char_class
    import cmd_pkg::*;
(
    input  logic [7:0] ch,
    output logic       is_bang,
    output logic       is_semi,
    output logic       is_hash,
    output logic       is_digit,
    output logic       is_upper,
    output logic [3:0] dval
);
    // Class decode of the incoming byte
    always_comb begin
        is_bang  = (ch == CH_BANG);
        is_semi  = (ch == CH_SEMI);
        is_hash  = (ch == CH_HASH);
        is_digit = (ch >= 8'h30) && (ch <= 8'h39);
        is_upper = (ch >= 8'h41) && (ch <= 8'h5A);
        dval     = ch[3:0];
    end
endmodule

// File: rtl/cmd_mnem_lookup.sv
`timescale 1ns/1ps
// Module: cmd_mnem_lookup
// Maps a collected mnemonic (zero-padded on the left, newest letter in
// the low byte) to a command code and the number of fields it expects.
// Assumes the name register is cleared at each frame start.
module cmd_mnem_lookup
    import cmd_pkg::*;
#(
    parameter int NAME_MAX = 3,
    parameter int CNTW     = 3,
    localparam int NAMEW   = 8 * NAME_MAX
) (
    input  logic [NAMEW-1:0] name,
    output logic             known,
    output cmd_code_e        code,
    output logic [CNTW-1:0]  nexp
);
    // Table of recognised mnemonics
    always_comb begin
        known = 1'b1;
        code  = CMD_NONE;
        nexp  = '0;
        if (name == NAMEW'("SC")) begin
            code = CMD_SC;  nexp = CNTW'(2);
        end else if (name == NAMEW'("TRO")) begin
            code = CMD_TRO; nexp = CNTW'(3);
        end else if (name == NAMEW'("TRF")) begin
            code = CMD_TRF; nexp = CNTW'(1);
        end else if (name == NAMEW'("PN")) begin
            code = CMD_PN;
        end else if (name == NAMEW'("PF")) begin
            code = CMD_PF;
        end else if (name == NAMEW'("GV")) begin
            code = CMD_GV;
        end else begin
            known = 1'b0;
        end
    end
endmodule

// File: rtl/cmd_field_acc.sv
`timescale 1ns/1ps
// Module: cmd_field_acc
// Decimal-to-binary accumulator for one field: value = value*10 + digit.
// Tracks the digit count and reports when no further digit fits.
// Assumes the controller never asks to add a digit when full is high.
module cmd_field_acc #(
    parameter int FIELD_W    = 17,
    parameter int MAX_DIGITS = 5,
    localparam int DW        = $clog2(MAX_DIGITS + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               first,
    input  logic               add,
    input  logic [3:0]         dval,
    output logic [FIELD_W-1:0] acc,
    output logic               full
);
    logic [DW-1:0] ndig_q;

    // Load the first digit or fold in a further one
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc    <= '0;
            ndig_q <= '0;
        end else if (first) begin
            acc    <= FIELD_W'(dval);
            ndig_q <= DW'(1);
        end else if (add) begin
            acc    <= acc * FIELD_W'(10) + FIELD_W'(dval);
            ndig_q <= ndig_q + DW'(1);
        end
    end

    assign full = (ndig_q == DW'(MAX_DIGITS));

    // R5: the controller only adds a digit while there is room for it
    p_add_room_r5: assert property (@(posedge clk) disable iff (!rst_n)
        add |-> (ndig_q < DW'(MAX_DIGITS)));
endmodule

// File: rtl/cmd_field_bank.sv
`timescale 1ns/1ps
// Module: cmd_field_bank
// Holds the converted field values of the frame being parsed, one slot
// per field, packed flat with slot 0 in the low bits. Cleared at each
// frame start so unused slots read zero.
module cmd_field_bank #(
    parameter int MAX_FIELDS = 6,
    parameter int FIELD_W    = 17,
    parameter int CNTW       = 3
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          clr,
    input  logic                          wr,
    input  logic [CNTW-1:0]               idx,
    input  logic [FIELD_W-1:0]            din,
    output logic [MAX_FIELDS*FIELD_W-1:0] dout
);
    for (genvar i = 0; i < MAX_FIELDS; i++) begin : g_slot
        logic [FIELD_W-1:0] slot_q;
        // Capture the finished field into its own slot
        always_ff @(posedge clk) begin
            if (!rst_n || clr)
                slot_q <= '0;
            else if (wr && (idx == CNTW'(i)))
                slot_q <= din;
        end
        assign dout[i*FIELD_W +: FIELD_W] = slot_q;
    end

    // R8: a write never targets a slot beyond the bank
    p_wr_idx_r8: assert property (@(posedge clk) disable iff (!rst_n)
        wr |-> (idx < CNTW'(MAX_FIELDS)));
endmodule

// File: rtl/cmd_frame_parser.sv
`timescale 1ns/1ps
// Module: cmd_frame_parser
// Recognises '!NAME;f;...;#' command frames and the bare '!!!' link
// request in a byte stream, converting decimal fields to binary as they
// arrive. Emits one-cycle frame or error strobes, registered one cycle
// after the deciding byte. Assumes at most one byte per clock.
module cmd_frame_parser
    import cmd_pkg::*;
#(
    parameter int MAX_FIELDS = 6,
    parameter int FIELD_W    = 17,
    parameter int MAX_DIGITS = 5,
    parameter int NAME_MAX   = 3,
    localparam int CNTW      = $clog2(MAX_FIELDS + 1)
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          rx_valid,
    input  logic [7:0]                    rx_byte,
    output logic                          frm_valid,
    output logic [2:0]                    frm_cmd,
    output logic [CNTW-1:0]               frm_nfields,
    output logic [MAX_FIELDS*FIELD_W-1:0] frm_fields,
    output logic                          err_valid,
    output logic [1:0]                    err_code
);
    localparam int NAMEW = 8 * NAME_MAX;
    localparam int NLW   = $clog2(NAME_MAX + 1);

    pstate_e            st_q, st_d;
    logic [NAMEW-1:0]   name_q;
    logic [NLW-1:0]     nlen_q;
    logic [CNTW-1:0]    fcnt_q;
    cmd_code_e          cur_code_q;
    logic [CNTW-1:0]    cur_nexp_q;
    cmd_code_e          frm_code_q;
    err_code_e          err_q;

    logic c_bang, c_semi, c_hash, c_digit, c_upper;
    logic [3:0] c_dval;
    logic lk_known;
    cmd_code_e lk_code;
    logic [CNTW-1:0] lk_nexp;
    logic [FIELD_W-1:0] acc;
    logic acc_full;

    logic start, name_shift, acc_first, acc_add, bank_wr, fcnt_inc, cur_ld;
    logic frm_set, err_set;
    cmd_code_e frm_code_d;
    logic [CNTW-1:0] frm_nf_d;
    err_code_e err_d;

    cmd_char_class u_class (
        .ch(rx_byte), .is_bang(c_bang), .is_semi(c_semi), .is_hash(c_hash),
        .is_digit(c_digit), .is_upper(c_upper), .dval(c_dval)
    );

    cmd_mnem_lookup #(.NAME_MAX(NAME_MAX), .CNTW(CNTW)) u_lookup (
        .name(name_q), .known(lk_known), .code(lk_code), .nexp(lk_nexp)
    );

    cmd_field_acc #(.FIELD_W(FIELD_W), .MAX_DIGITS(MAX_DIGITS)) u_acc (
        .clk(clk), .rst_n(rst_n), .first(acc_first), .add(acc_add),
        .dval(c_dval), .acc(acc), .full(acc_full)
    );

    cmd_field_bank #(.MAX_FIELDS(MAX_FIELDS), .FIELD_W(FIELD_W), .CNTW(CNTW)) u_bank (
        .clk(clk), .rst_n(rst_n), .clr(start), .wr(bank_wr), .idx(fcnt_q),
        .din(acc), .dout(frm_fields)
    );

    // Next-state and control decode for one accepted byte
    always_comb begin
        st_d       = st_q;
        start      = 1'b0;
        name_shift = 1'b0;
        acc_first  = 1'b0;
        acc_add    = 1'b0;
        bank_wr    = 1'b0;
        fcnt_inc   = 1'b0;
        cur_ld     = 1'b0;
        frm_set    = 1'b0;
        frm_code_d = cur_code_q;
        frm_nf_d   = fcnt_q;
        err_set    = 1'b0;
        err_d      = ERR_SYNTAX;
        if (rx_valid) begin
            if (c_bang && (st_q != ST_BANG1) && (st_q != ST_BANG2)) begin
                start = 1'b1;
                st_d  = ST_BANG1;
            end else begin
                case (st_q)
                    ST_HUNT: st_d = ST_HUNT;
                    ST_BANG1: begin
                        if (c_bang) begin
                            st_d = ST_BANG2;
                        end else if (c_upper) begin
                            name_shift = 1'b1;
                            st_d = ST_NAME;
                        end else begin
                            err_set = 1'b1;
                            st_d = ST_HUNT;
                        end
                    end
                    ST_BANG2: begin
                        if (c_bang) begin
                            frm_set    = 1'b1;
                            frm_code_d = CMD_LINK;
                            frm_nf_d   = '0;
                            st_d = ST_HUNT;
                        end else if (c_upper) begin
                            name_shift = 1'b1;
                            st_d = ST_NAME;
                        end else begin
                            err_set = 1'b1;
                            st_d = ST_HUNT;
                        end
                    end
                    ST_NAME: begin
                        if (c_upper && (nlen_q == NLW'(NAME_MAX))) begin
                            err_set = 1'b1;
                            err_d = ERR_UNKNOWN;
                            st_d = ST_HUNT;
                        end else if (c_upper) begin
                            name_shift = 1'b1;
                        end else if (c_semi && lk_known) begin
                            cur_ld = 1'b1;
                            st_d = ST_SEP;
                        end else begin
                            err_set = 1'b1;
                            err_d = c_semi ? ERR_UNKNOWN : ERR_SYNTAX;
                            st_d = ST_HUNT;
                        end
                    end
                    ST_SEP: begin
                        if (c_hash) begin
                            if (fcnt_q == cur_nexp_q) begin
                                frm_set = 1'b1;
                            end else begin
                                err_set = 1'b1;
                                err_d = ERR_COUNT;
                            end
                            st_d = ST_HUNT;
                        end else if (c_digit) begin
                            acc_first = 1'b1;
                            st_d = ST_FIELD;
                        end else begin
                            err_set = 1'b1;
                            st_d = ST_HUNT;
                        end
                    end
                    ST_FIELD: begin
                        if (c_digit && acc_full) begin
                            err_set = 1'b1;
                            err_d = ERR_OVERFLOW;
                            st_d = ST_HUNT;
                        end else if (c_digit) begin
                            acc_add = 1'b1;
                        end else if (c_semi && (fcnt_q == CNTW'(MAX_FIELDS))) begin
                            err_set = 1'b1;
                            err_d = ERR_COUNT;
                            st_d = ST_HUNT;
                        end else if (c_semi) begin
                            bank_wr  = 1'b1;
                            fcnt_inc = 1'b1;
                            st_d = ST_SEP;
                        end else begin
                            err_set = 1'b1;
                            st_d = ST_HUNT;
                        end
                    end
                    default: st_d = ST_HUNT;
                endcase
            end
        end
    end

    // Parser state, mnemonic collection and field counting
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q       <= ST_HUNT;
            name_q     <= '0;
            nlen_q     <= '0;
            fcnt_q     <= '0;
            cur_code_q <= CMD_NONE;
            cur_nexp_q <= '0;
        end else begin
            st_q <= st_d;
            if (start) begin
                name_q <= '0;
                nlen_q <= '0;
                fcnt_q <= '0;
            end else begin
                if (name_shift) begin
                    name_q <= {name_q[NAMEW-9:0], rx_byte};
                    nlen_q <= nlen_q + NLW'(1);
                end
                if (fcnt_inc)
                    fcnt_q <= fcnt_q + CNTW'(1);
            end
            if (cur_ld) begin
                cur_code_q <= lk_code;
                cur_nexp_q <= lk_nexp;
            end
        end
    end

    // Registered result strobes and their payload
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            frm_valid   <= 1'b0;
            frm_code_q  <= CMD_NONE;
            frm_nfields <= '0;
            err_valid   <= 1'b0;
            err_q       <= ERR_SYNTAX;
        end else begin
            frm_valid <= frm_set;
            err_valid <= err_set;
            if (frm_set) begin
                frm_code_q  <= frm_code_d;
                frm_nfields <= frm_nf_d;
            end
            if (err_set)
                err_q <= err_d;
        end
    end

    assign frm_cmd  = frm_code_q;
    assign err_code = err_q;

    // R1: strobes are low on the cycle after reset
    p_reset_quiet_r1: assert property (@(posedge clk)
        !rst_n |=> (!frm_valid && !err_valid));
    // R2: a normal frame is reported only right after a '#'
    p_end_hash_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (frm_valid && (frm_cmd != CMD_LINK)) |-> ($past(rx_valid) && ($past(rx_byte) == CH_HASH)));
    // R3: a link request follows a '!' and carries no fields
    p_link_bang_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (frm_valid && (frm_cmd == CMD_LINK)) |-> (($past(rx_byte) == CH_BANG) && (frm_nfields == '0)));
    // R11: the two strobes exclude each other
    p_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !(frm_valid && err_valid));
    // R11: frame strobe lasts one cycle
    p_frm_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
        frm_valid |=> !frm_valid);
    // R11: error strobe lasts one cycle
    p_err_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
        err_valid |=> !err_valid);
    // R12: any strobe traces back to an accepted byte
    p_consume_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (frm_valid || err_valid) |-> $past(rx_valid));
endmodule

// File: tb/cmd_frame_parser_test.sv
`timescale 1ns/1ps
module cmd_frame_parser_test;
    localparam int W = 17;
    localparam int NF = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic rx_valid = 1'b0;
    logic [7:0] rx_byte = 8'h00;
    logic frm_valid, err_valid;
    logic [2:0] frm_cmd, frm_nfields;
    logic [NF*W-1:0] frm_fields;
    logic [1:0] err_code;

    cmd_frame_parser uut (
        .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_byte(rx_byte),
        .frm_valid(frm_valid), .frm_cmd(frm_cmd), .frm_nfields(frm_nfields),
        .frm_fields(frm_fields), .err_valid(err_valid), .err_code(err_code)
    );

    always #2 clk = ~clk;

    int nchk = 0, nfail = 0;
    int mon_frames = 0, mon_errs = 0;
    int cap_cmd, cap_nf, cap_err;
    int cap_f[NF];
    int ef[NF];
    int f0, e0;
    bit gaps = 1'b0;
    logic prev_frm = 1'b0, prev_err = 1'b0;

    task automatic chk(bit ok, string req, string what, int act, int exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    endtask

    // Output monitor, sampled on the falling edge
    always @(negedge clk) begin
        if (rst_n) begin
            if ((frm_valid && err_valid) || (frm_valid && prev_frm) || (err_valid && prev_err)) begin
                nchk++; nfail++;
                $display("FAIL R11 strobe overlap/width actual=%0d expected=0", {frm_valid, err_valid});
            end
            if (frm_valid) begin
                mon_frames++;
                cap_cmd = int'(frm_cmd);
                cap_nf  = int'(frm_nfields);
                for (int i = 0; i < NF; i++) cap_f[i] = int'(frm_fields[i*W +: W]);
            end
            if (err_valid) begin
                mon_errs++;
                cap_err = int'(err_code);
            end
        end
        prev_frm = frm_valid;
        prev_err = err_valid;
    end

    initial begin
        repeat (100000) @(posedge clk);
        nchk++; nfail++;
        $display("FAIL watchdog actual=timeout expected=done");
        finish_run();
    end

    task automatic send_byte(logic [7:0] b);
        if (gaps) begin
            int g = $urandom_range(0, 2);
            repeat (g) begin
                @(negedge clk);
                rx_valid = 1'b0;
                rx_byte = 8'($urandom);
            end
        end
        @(negedge clk);
        rx_valid = 1'b1;
        rx_byte = b;
        @(negedge clk);
        rx_valid = 1'b0;
    endtask

    task automatic send_str(string s);
        f0 = mon_frames; e0 = mon_errs;
        for (int i = 0; i < s.len(); i++) send_byte(s[i]);
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic clear_ef();
        for (int i = 0; i < NF; i++) ef[i] = 0;
    endtask

    task automatic expect_frame(string req, int code, int nf);
        chk(mon_frames - f0 == 1, req, "frame count", mon_frames - f0, 1);
        chk(mon_errs - e0 == 0, req, "error count", mon_errs - e0, 0);
        chk(cap_cmd == code, req, "command code", cap_cmd, code);
        chk(cap_nf == nf, req, "field count", cap_nf, nf);
        for (int i = 0; i < NF; i++)
            chk(cap_f[i] == ef[i], req, $sformatf("field %0d", i), cap_f[i], ef[i]);
    endtask

    task automatic expect_err(string req, int code);
        chk(mon_frames - f0 == 0, req, "frame count", mon_frames - f0, 0);
        chk(mon_errs - e0 == 1, req, "error count", mon_errs - e0, 1);
        chk(cap_err == code, req, "error code", cap_err, code);
    endtask

    task automatic expect_none(string req);
        chk(mon_frames - f0 == 0, req, "frame count", mon_frames - f0, 0);
        chk(mon_errs - e0 == 0, req, "error count", mon_errs - e0, 0);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(!frm_valid && !err_valid, "R1", "strobes in reset", {frm_valid, err_valid}, 0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!frm_valid && !err_valid, "R1", "strobes after reset", {frm_valid, err_valid}, 0);
        chk(frm_cmd == 0 && frm_nfields == 0, "R1", "cmd/count after reset", {frm_cmd, frm_nfields}, 0);
        chk(frm_fields == '0, "R1", "fields after reset", int'(frm_fields[W-1:0]), 0);

        // R3: link request
        clear_ef(); send_str("!!!"); expect_frame("R3", 1, 0);
        // R2 R4: set-current example and boundaries
        clear_ef(); ef[0] = 5; ef[1] = 25415;
        send_str("!SC;5;25415;#"); expect_frame("R2", 2, 2);
        clear_ef(); ef[0] = 99; ef[1] = 99999;
        send_str("!SC;99;99999;#"); expect_frame("R4", 2, 2);
        clear_ef(); ef[0] = 7; ef[1] = 0;
        send_str("!SC;007;00000;#"); expect_frame("R4", 2, 2);
        clear_ef(); ef[0] = 3; ef[1] = 12000; ef[2] = 500;
        send_str("!TRO;3;12000;500;#"); expect_frame("R2", 3, 3);
        clear_ef(); ef[0] = 11; send_str("!TRF;11;#"); expect_frame("R2", 4, 1);
        clear_ef(); send_str("!PN;#"); expect_frame("R2", 5, 0);
        clear_ef(); send_str("!PF;#"); expect_frame("R2", 6, 0);
        clear_ef(); send_str("!GV;#"); expect_frame("R2", 7, 0);
        // R5 R10: overflow, then leftover bytes ignored
        send_str("!SC;5;123456"); expect_err("R5", 1);
        send_str(";#"); expect_none("R10");
        // R6: syntax errors
        send_str("!SC;5A;#"); expect_err("R6", 0);
        send_str("!SC;;#"); expect_err("R6", 0);
        send_str("!3"); expect_err("R6", 0);
        // R7: unknown mnemonics
        send_str("!XY;#"); expect_err("R7", 2);
        send_str("!ABCD"); expect_err("R7", 2);
        // R8: field count
        send_str("!SC;5;#"); expect_err("R8", 3);
        send_str("!PN;1;#"); expect_err("R8", 3);
        send_str("!TRO;1;1;1;1;1;1;1;"); expect_err("R8", 3);
        // R9: restart mid-frame, slots cleared
        clear_ef(); send_str("!SC;5;2!GV;#"); expect_frame("R9", 7, 0);
        clear_ef(); send_str("!S!PN;#"); expect_frame("R9", 5, 0);
        // R10: garbage before a frame
        send_str("5;#ZZ;#"); expect_none("R10");
        // R12: bytes with rx_valid low
        f0 = mon_frames; e0 = mon_errs;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk); rx_valid = 1'b0; rx_byte = 8'h21;
        end
        @(negedge clk); @(negedge clk);
        expect_none("R12");
        clear_ef(); send_str("!PF;#"); expect_frame("R12", 6, 0);

        // Random frames with idle gaps
        gaps = 1'b1;
        for (int it = 0; it < 60; it++) begin
            int kind = $urandom_range(0, 6);
            int ch = $urandom_range(0, 99);
            int cur = $urandom_range(0, 99999);
            int tm = $urandom_range(0, 99999);
            clear_ef();
            case (kind)
                0: begin send_str("!!!"); expect_frame("R3", 1, 0); end
                1: begin ef[0] = ch; ef[1] = cur;
                    send_str($sformatf("!SC;%0d;%0d;#", ch, cur)); expect_frame("R4", 2, 2); end
                2: begin ef[0] = ch; ef[1] = cur; ef[2] = tm;
                    send_str($sformatf("!TRO;%0d;%0d;%0d;#", ch, cur, tm)); expect_frame("R4", 3, 3); end
                3: begin ef[0] = ch;
                    send_str($sformatf("!TRF;%0d;#", ch)); expect_frame("R2", 4, 1); end
                4: begin
                    case (ch % 3)
                        0: begin send_str("!PN;#"); expect_frame("R2", 5, 0); end
                        1: begin send_str("!PF;#"); expect_frame("R2", 6, 0); end
                        default: begin send_str("!GV;#"); expect_frame("R2", 7, 0); end
                    endcase
                end
                5: begin send_str($sformatf("!SC;%0d;#", ch)); expect_err("R8", 3); end
                default: begin
                    send_str($sformatf("!TRF;1%05d", cur)); expect_err("R5", 1);
                    send_str(";#"); expect_none("R10");
                end
            endcase
        end
        finish_run();
    end
endmodule